// File: doc/BRIEF.md
# Nonzero Activation Extractor

This block takes one vector of activations from a local activation buffer and sends out only the nonzero lanes, one per cycle. Each lane it sends carries its original lane index, so the vector processing elements downstream can select the matching weight column. It sits between the activation buffer and the distribution network. Zero lanes cost no cycles on the output.

A load/ready handshake accepts a whole vector into a local register. A per-lane pending mask starts as the vector's nonzero map. Each cycle, a priority search picks the lowest pending lane and offers it on a valid/ready handshake. When the network accepts that lane, its pending bit is cleared. The search then moves to the next lane on the following cycle.

When the mask becomes empty, a one-cycle end-of-vector pulse marks the boundary. A new vector can only be accepted once the mask is empty.

Top module: `nz_broadcast`

## Requirements
- R1: After reset, `nz_valid` and `nz_eov` are low and `ld_ready` is high.
- R2: `ld_ready` is high exactly when no lane is pending. A vector is taken on a clock edge where `ld_valid` and `ld_ready` are both high. Its first nonzero lane is offered in the next cycle.
- R3: A lane whose 16-bit value is zero is never offered. Whenever `nz_valid` is high, `nz_data` is nonzero.
- R4: Pending lanes are offered in strictly increasing index order, starting from the lowest index (lane 0 is bits [15:0] of `ld_vec`, lane k is bits [16k+15:16k]).
- R5: Each offered element has `nz_idx` equal to its lane number and `nz_data` equal to that lane's loaded value, including negative values.
- R6: While `nz_valid` is high and `nz_ready` is low, the next cycle keeps `nz_valid` high with the same `nz_idx` and `nz_data`.
- R7: `nz_eov` is high for exactly the one cycle after the edge that accepts the last nonzero lane. `nz_valid` is low in that cycle.
- R8: A vector whose lanes are all zero produces no element. It produces only `nz_eov` in the cycle after it is loaded.
- R9: An `ld_valid` while `ld_ready` is low is ignored. The vector being sent keeps going unchanged.
- R10: Each nonzero lane is offered and accepted exactly once per loaded vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Buffer presents a vector |
| ld_vec | input | LANES*DW | Activation vector, lane k in bits [DW*k +: DW] |
| ld_ready | output | 1 | Block can take a new vector (no lane pending) |
| nz_valid | output | 1 | A nonzero element is offered |
| nz_ready | input | 1 | Network accepts the offered element |
| nz_idx | output | IW | Lane index of the offered element |
| nz_data | output | DW | Value of the offered element |
| nz_eov | output | 1 | One-cycle end-of-vector pulse |

## Verification
There is one register stage on each path:
- A vector loaded at edge k shows its first element, or for an all-zero vector the end-of-vector pulse, after edge k.
- Each acceptance brings up the next element one edge later.
- The end-of-vector pulse follows the last acceptance by one edge and drops at the edge after that.

The bench drives inputs and samples outputs only on falling edges. Each sample therefore sees exactly the state left by the preceding rising edge. Expected elements are taken by scanning the stimulus vector for nonzero lanes, in order, and stalls are inserted by a per-entry ready pattern.

// File: rtl/nz_broadcast.sv
module nz_broadcast #(
  parameter int LANES = 16,
  parameter int DW    = 16,
  localparam int IW   = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_valid,
  input  logic [LANES*DW-1:0]   ld_vec,
  output logic                  ld_ready,
  output logic                  nz_valid,
  input  logic                  nz_ready,
  output logic [IW-1:0]         nz_idx,
  output logic [DW-1:0]         nz_data,
  output logic                  nz_eov
);

  logic [LANES*DW-1:0] vec_q;
  logic [LANES-1:0]    pend_q, nz_map, clr_mask;
  logic [IW-1:0]       sel;
  logic                eov_q, ld_fire, out_fire;

  for (genvar g = 0; g < LANES; g++) begin : g_map
    assign nz_map[g] = |ld_vec[g*DW +: DW];
  end

  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend_q[i]) sel = IW'(i);
  end

  assign clr_mask = LANES'(1) << sel;
  assign ld_ready = ~|pend_q;
  assign nz_valid = |pend_q;
  assign nz_idx   = sel;
  assign nz_data  = vec_q[sel*DW +: DW];
  assign nz_eov   = eov_q;
  assign ld_fire  = ld_valid & ld_ready;
  assign out_fire = nz_valid & nz_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      pend_q <= '0;
      eov_q  <= 1'b0;
    end else begin
      eov_q <= (ld_fire && nz_map == '0) || (out_fire && (pend_q & ~clr_mask) == '0);
      if (ld_fire) begin
        vec_q  <= ld_vec;
        pend_q <= nz_map;
      end else if (out_fire) begin
        pend_q <= pend_q & ~clr_mask;
      end
    end
  end

  assert_no_zero_sent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nz_valid |-> nz_data != '0);

  assert_load_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> !nz_valid);

  assert_rising_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_valid && nz_ready) |=> (!nz_valid || nz_idx > $past(nz_idx)));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_valid && !nz_ready) |=> (nz_valid && $stable(nz_idx) && $stable(nz_data)));

  assert_eov_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nz_eov |-> !nz_valid);

  assert_sent_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_valid && nz_ready) |=> !(nz_valid && nz_idx == $past(nz_idx)));

endmodule

// File: tb/nz_broadcast_tb_top.sv
module nz_broadcast_tb_top;
  localparam int LANES = 16;
  localparam int DW    = 16;
  localparam int IW    = 4;
  localparam int NV    = 5;

  localparam logic [LANES*DW-1:0] VECS [NV] = '{
    256'h0010_000F_000E_000D_000C_000B_000A_0009_0008_0007_0006_0005_0004_0003_0002_0001,
    256'h8000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_FFFF,
    256'h0000_7FFF_0000_0000_0000_0005_0000_0000_0000_0000_0003_0000_0000_0000_0000_0000,
    256'h0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000,
    256'h0000_0000_0000_0000_0000_0000_0000_0000_0100_0000_0000_0000_0000_0000_0000_0000
  };
  localparam int STALL [NV] = '{0, 2, 3, 0, 2};

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, nz_ready = 0;
  logic [LANES*DW-1:0] ld_vec = '0;
  logic ld_ready, nz_valid, nz_eov;
  logic [IW-1:0] nz_idx;
  logic [DW-1:0] nz_data;
  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nz_broadcast #(.LANES(LANES), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_vec(ld_vec),
    .ld_ready(ld_ready), .nz_valid(nz_valid), .nz_ready(nz_ready),
    .nz_idx(nz_idx), .nz_data(nz_data), .nz_eov(nz_eov));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic load(input logic [LANES*DW-1:0] v);
    @(negedge clk);
    chk(ld_ready, "R2 ready before load", ld_ready, 1);
    ld_vec = v; ld_valid = 1;
    @(negedge clk);
    ld_valid = 0;
  endtask

  // Consume the current vector; when intrude is set, offer a second vector mid-stream (R9).
  task automatic drain(input logic [LANES*DW-1:0] v, input int stall, input bit intrude);
    int cnt = 0;
    for (int k = 0; k < LANES; k++) begin
      logic [DW-1:0] lv = v[k*DW +: DW];
      if (lv != 0) begin
        bit taken = 0;
        while (!taken) begin
          cnt++;
          chk(nz_valid, "R3 valid while pending", nz_valid, 1);
          chk(nz_idx == IW'(k), "R4 index order", nz_idx, k);
          chk(nz_data == lv, "R5 value", nz_data, lv);
          chk(!ld_ready, "R2 busy", ld_ready, 0);
          nz_ready = (stall == 0) || (cnt % stall != 0);
          if (intrude) begin ld_vec = {LANES{16'h0BAD}}; ld_valid = 1; end
          if (!nz_ready) begin
            @(negedge clk);
            chk(nz_valid && nz_idx == IW'(k), "R6 stall hold", nz_idx, k);
            continue;
          end
          taken = 1;
          @(negedge clk);
          nz_ready = 0; ld_valid = 0;
        end
      end
    end
    chk(nz_eov, "R7 eov pulse", nz_eov, 1);
    chk(!nz_valid, "R10 no extra element", nz_valid, 0);
    chk(ld_ready, "R2 ready when empty", ld_ready, 1);
    @(negedge clk);
    chk(!nz_eov, "R7 eov one cycle", nz_eov, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!nz_valid && !nz_eov && ld_ready, "R1 reset state",
        {nz_valid, nz_eov, ld_ready}, 3'b001);
    rst_n = 1;
    for (int t = 0; t < NV; t++) begin
      load(VECS[t]);
      if (VECS[t] == '0) begin
        chk(nz_eov && !nz_valid, "R8 all-zero gives only eov", {nz_eov, nz_valid}, 2'b10);
        @(negedge clk);
        chk(!nz_eov && !nz_valid, "R8 eov single", {nz_eov, nz_valid}, 2'b00);
      end else begin
        drain(VECS[t], STALL[t], 1'b0);
      end
    end
    load(VECS[2]);
    drain(VECS[2], 0, 1'b1);
    chk(!nz_valid, "R9 intruding vector not loaded", nz_valid, 0);
    @(negedge clk);
    nz_ready = 1;
    rst_n = 0; ld_vec = VECS[0]; ld_valid = 1;
    @(negedge clk);
    ld_valid = 0;
    @(negedge clk);
    chk(!nz_valid && ld_ready, "R1 reset ignores load", nz_valid, 0);
    finish_run();
  end
endmodule